// File: doc/BRIEF.md
# RMII Receive Dibit Serializer

This block sits on the PHY side of a reduced media-independent interface link and turns received bytes into the two-bit receive lanes that a MAC expects. It takes bytes from an internal byte stream and pops them one at a time. Each byte carries a valid flag, a start-of-packet flag, an end-of-packet flag and an error flag. From these it drives `crs_dv` and `rxd[1:0]` on a 50 MHz reference clock. When carrier is seen it raises `crs_dv` at once. It holds `rxd` at 00 until the first start-of-packet byte is available. It then sends a preamble of repeated 01 dibits closed by an 11 delimiter, followed by the frame bytes, four dibits per byte.

A byte flagged as errored forces the lanes to 10 for the rest of the activity. This covers a false carrier, when the flag is on the very first byte, and a symbol error later in the frame. A byte stream that runs dry in the middle of a frame is handled the same way. At 10 Mb/s every output value is stretched over ten reference clocks. The rate is latched only while the block is idle.

Top module: `rmii_rx_serializer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `crs_dv` is 0 and `rxd` is 00 from the next cycle on.
- R2: While idle, `crs_dv` is 0, `rxd` is 00 and `byte_pop` stays 0 even when `byte_valid` is high.
- R3: `carrier_in` high while idle raises `crs_dv` on the next cycle. `rxd` then holds 00 until a byte with `byte_sop` set is popped. Bytes popped before that without `byte_sop` are discarded. If `carrier_in` falls in that phase, the block returns to idle.
- R4: After the start-of-packet byte is taken, `rxd` shows PRE_LEN dibits of 01 and then one dibit of 11.
- R5: Each byte follows as four dibits, bits [1:0] first and bits [7:6] last, with `rxd[0]` carrying the lower bit of each pair.
- R6: After the last dibit of a byte flagged with `byte_eop`, `crs_dv` drops to 0 and `rxd` to 00 on the next cycle.
- R7: Popping a byte with `byte_err` set makes `rxd` 10 with `crs_dv` 1 from the next dibit slot on. This also applies to the first byte (false carrier). It lasts until `carrier_in` is low, and the block then returns to idle.
- R8: If no byte is valid when a non-final byte's last dibit ends, the block behaves as in R7.
- R9: With `speed_10` = 1 (10 Mb/s), every output value outside the error phase lasts a multiple of STRETCH (10) clocks. With `speed_10` = 0 (100 Mb/s), each dibit lasts one clock.
- R10: `speed_10` is sampled only while idle, so a change during an activity does not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| speed_10 | input | 1 | 1 = 10 Mb/s, 0 = 100 Mb/s; sampled while idle |
| carrier_in | input | 1 | Carrier detected on the line |
| byte_valid | input | 1 | A byte is available on the stream |
| byte_sop | input | 1 | Byte is the first of a frame |
| byte_eop | input | 1 | Byte is the last of a frame |
| byte_err | input | 1 | Byte carries a symbol error or false carrier |
| byte_data | input | DATA_W | Received byte |
| byte_pop | output | 1 | Byte is consumed at this clock edge |
| crs_dv | output | 1 | Carrier sense / data valid |
| rxd | output | 2 | Receive dibit, rxd[0] is the lower bit |

## Verification
The bound checker watches several properties on every cycle. It checks the quiet state during reset and while idle. It checks that the 00 hold lasts as long as the block waits for data. It checks that the error code stays in place while carrier lasts, and that the latched rate stays stable through an activity. At 10 Mb/s it also checks that every paced output run has a length that is a multiple of ten clocks. Other behaviours can only be shown by the bench's frame scenarios, by comparing the full dibit sequence: the exact preamble count, the least-significant-first byte order, the discarding of bytes without a start flag, the point where an error or an underrun cuts a frame short, and the length of the leading 00 hold at 100 Mb/s.

// File: rtl/rmii_rx_pkg.sv
// Shared types and line codes for the receive dibit serializer.
// Assumes a two-bit data path toward the MAC.
package rmii_rx_pkg;

    // Activity phases of the serializer
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_PRE  = 3'd2,
        ST_DATA = 3'd3,
        ST_ERR  = 3'd4
    } rx_state_t;

    localparam logic [1:0] DIB_QUIET = 2'b00;
    localparam logic [1:0] DIB_PRE   = 2'b01;
    localparam logic [1:0] DIB_SFD   = 2'b11;
    localparam logic [1:0] DIB_ERR   = 2'b10;

endpackage

// File: rtl/rmii_rx_pace.sv
// Symbol pacing for the serializer.
// Latches the rate select while idle and produces an advance strobe:
// every cycle at 100 Mb/s, every STRETCH cycles at 10 Mb/s.
// Assumes the counter restarts at the first cycle of each activity.
module rmii_rx_pace #(
    parameter int STRETCH = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    input  logic speed_10,
    output logic slow_lat,
    output logic adv
);

    localparam int CW = (STRETCH > 1) ? $clog2(STRETCH) : 1;
    localparam logic [CW-1:0] LAST = CW'(STRETCH - 1);

    logic [CW-1:0] cnt;

    // Rate latch and stretch counter; both frozen outside their phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_lat <= 1'b0;
            cnt      <= '0;
        end else if (idle) begin
            slow_lat <= speed_10;
            cnt      <= '0;
        end else if (slow_lat) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // Advance strobe: each slot ends on the last count at 10 Mb/s
    always_comb begin
        adv = !slow_lat || (cnt == LAST);
    end

endmodule

// File: rtl/rmii_rx_seq.sv
// Activity sequencer for the serializer.
// Walks idle -> wait -> preamble -> data, pops bytes from the stream,
// and diverts to the error phase on a flagged byte or a stream underrun.
// Assumes every change of phase except carrier loss falls on an advance strobe.
module rmii_rx_seq
    import rmii_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int PRE_LEN = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              carrier_in,
    input  logic              byte_valid,
    input  logic              byte_sop,
    input  logic              byte_eop,
    input  logic              byte_err,
    input  logic [DATA_W-1:0] byte_data,
    output logic              byte_pop,
    output rx_state_t         state,
    output logic              pre_last,
    output logic [DATA_W-1:0] hold,
    output logic [((DATA_W/2 > 1) ? $clog2(DATA_W/2) : 1)-1:0] lane
);

    localparam int LANES = DATA_W / 2;
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int PW    = $clog2(PRE_LEN + 1) + 1;
    localparam logic [LW-1:0] LAST_LANE = LW'(LANES - 1);
    localparam logic [PW-1:0] PRE_END   = PW'(PRE_LEN);

    logic [PW-1:0] pre_cnt;
    logic          last_q;
    logic          at_boundary;
    logic          take;

    // Byte boundary: last dibit of a held byte ends at this edge
    always_comb begin
        at_boundary = (state == ST_DATA) && adv && (lane == LAST_LANE);
    end

    // Pop decision: first byte while waiting, next byte at a boundary
    always_comb begin
        take = byte_valid && adv &&
               (((state == ST_WAIT) && carrier_in) ||
                (at_boundary && !last_q));
        byte_pop = take;
    end

    // Preamble end flag for the output decoder
    always_comb begin
        pre_last = (pre_cnt == PRE_END);
    end

    // Phase register with byte holding and slot counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pre_cnt <= '0;
            lane    <= '0;
            hold    <= '0;
            last_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (carrier_in) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (!carrier_in) begin
                        state <= ST_IDLE;
                    end else if (take) begin
                        if (byte_err) begin
                            state <= ST_ERR;
                        end else if (byte_sop) begin
                            state   <= ST_PRE;
                            hold    <= byte_data;
                            last_q  <= byte_eop;
                            pre_cnt <= '0;
                        end
                    end
                end
                ST_PRE: begin
                    if (adv) begin
                        if (pre_last) begin
                            state <= ST_DATA;
                            lane  <= '0;
                        end else begin
                            pre_cnt <= pre_cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (at_boundary) begin
                        if (last_q) begin
                            state <= ST_IDLE;
                        end else if (take) begin
                            if (byte_err) begin
                                state <= ST_ERR;
                            end else begin
                                hold   <= byte_data;
                                last_q <= byte_eop;
                                lane   <= '0;
                            end
                        end else begin
                            state <= ST_ERR;
                        end
                    end else if (adv) begin
                        lane <= lane + 1'b1;
                    end
                end
                ST_ERR: begin
                    if (!carrier_in) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rmii_rx_drive.sv
// Output decoder for the serializer.
// Maps the phase, preamble position and held byte onto crs_dv and rxd.
// Assumes the held byte is split into dibit lanes, lowest lane sent first.
module rmii_rx_drive
    import rmii_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  rx_state_t         state,
    input  logic              pre_last,
    input  logic [DATA_W-1:0] hold,
    input  logic [((DATA_W/2 > 1) ? $clog2(DATA_W/2) : 1)-1:0] lane,
    output logic              crs_dv,
    output logic [1:0]        rxd
);

    localparam int LANES = DATA_W / 2;

    logic [1:0] lanes [LANES];

    // Split the held byte into dibit lanes
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = hold[2*g +: 2];
    end

    // Line decode: quiet, preamble, delimiter, data or error code
    always_comb begin
        crs_dv = (state != ST_IDLE);
        case (state)
            ST_PRE:  rxd = pre_last ? DIB_SFD : DIB_PRE;
            ST_DATA: rxd = lanes[lane];
            ST_ERR:  rxd = DIB_ERR;
            default: rxd = DIB_QUIET;
        endcase
    end

endmodule

// File: rtl/rmii_rx_serializer.sv
// Receive dibit serializer, top level.
// Converts a popped byte stream into crs_dv / rxd on the reference clock,
// with preamble insertion, in-band error code and 10 Mb/s stretching.
// Assumes the byte stream holds its flags stable while byte_valid is high.
module rmii_rx_serializer
    import rmii_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int PRE_LEN = 7,
    parameter int STRETCH = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              speed_10,
    input  logic              carrier_in,
    input  logic              byte_valid,
    input  logic              byte_sop,
    input  logic              byte_eop,
    input  logic              byte_err,
    input  logic [DATA_W-1:0] byte_data,
    output logic              byte_pop,
    output logic              crs_dv,
    output logic [1:0]        rxd
);

    localparam int LANES = DATA_W / 2;
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;

    rx_state_t         fsm_state;
    logic              speed_lat;
    logic              adv;
    logic              pre_last;
    logic [DATA_W-1:0] hold;
    logic [LW-1:0]     lane;
    logic              is_idle;

    // Idle indication for the pacing block
    always_comb begin
        is_idle = (fsm_state == ST_IDLE);
    end

    rmii_rx_pace #(.STRETCH(STRETCH)) u_pace (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle     (is_idle),
        .speed_10 (speed_10),
        .slow_lat (speed_lat),
        .adv      (adv)
    );

    rmii_rx_seq #(.DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .carrier_in (carrier_in),
        .byte_valid (byte_valid),
        .byte_sop   (byte_sop),
        .byte_eop   (byte_eop),
        .byte_err   (byte_err),
        .byte_data  (byte_data),
        .byte_pop   (byte_pop),
        .state      (fsm_state),
        .pre_last   (pre_last),
        .hold       (hold),
        .lane       (lane)
    );

    rmii_rx_drive #(.DATA_W(DATA_W)) u_drive (
        .state    (fsm_state),
        .pre_last (pre_last),
        .hold     (hold),
        .lane     (lane),
        .crs_dv   (crs_dv),
        .rxd      (rxd)
    );

endmodule

// File: rtl/rmii_rx_serializer_chk.sv
// Property checker for the receive dibit serializer, bound to the top.
// Assumes it sees the phase register and latched rate of the top.
module rmii_rx_serializer_chk
    import rmii_rx_pkg::*;
#(
    parameter int STRETCH = 10
) (
    input logic      clk,
    input logic      rst_n,
    input logic      carrier_in,
    input logic      byte_pop,
    input logic      crs_dv,
    input logic [1:0] rxd,
    input rx_state_t st,
    input logic      spd_q
);

    logic [2:0]  cur_val;
    logic [2:0]  prev_val;
    logic [15:0] run_cnt;
    rx_state_t   prev_st;
    logic        changed;
    logic        paced_end;

    assign cur_val   = {crs_dv, rxd};
    assign changed   = (cur_val != prev_val);
    assign paced_end = (prev_st == ST_PRE) || (prev_st == ST_DATA) ||
                       ((prev_st == ST_WAIT) && (st != ST_IDLE));

    // Track the length of the current output run and the previous phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_val <= 3'b000;
            run_cnt  <= 16'd1;
            prev_st  <= ST_IDLE;
        end else begin
            prev_val <= cur_val;
            prev_st  <= st;
            run_cnt  <= changed ? 16'd1 : run_cnt + 16'd1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!crs_dv && rxd == 2'b00));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !crs_dv |-> (rxd == 2'b00 && !byte_pop));

    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> (crs_dv && rxd == 2'b00));

    // R3
    dv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crs_dv) |-> (rxd == 2'b00));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERR && carrier_in) |=> (st == ST_ERR && crs_dv && rxd == DIB_ERR));

    // R9
    stretch_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (changed && paced_end && spd_q) |-> ((32'(run_cnt) % STRETCH) == 0));

    // R10
    rate_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(spd_q));

endmodule

bind rmii_rx_serializer rmii_rx_serializer_chk #(.STRETCH(STRETCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrier_in (carrier_in),
    .byte_pop   (byte_pop),
    .crs_dv     (crs_dv),
    .rxd        (rxd),
    .st         (fsm_state),
    .spd_q      (speed_lat)
);

// File: tb/tb_rmii_rx_serializer.sv
// Bench for the receive dibit serializer: table-driven frames, then directed cases.
module tb_rmii_rx_serializer;

    localparam int PRE_LEN = 7;
    localparam int STRETCH = 10;

    typedef struct packed {
        logic        slow;
        logic        flip;
        logic [3:0]  gap;
        logic [2:0]  nbytes;
        logic [31:0] bytes;
        logic [2:0]  err_idx;
        logic        nosop;
        logic        eop;
        logic        exp_err;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 4'd0, 3'd2, 32'h00003CA5, 3'd7, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b0, 4'd3, 3'd3, 32'h0096FF00, 3'd7, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b0, 4'd0, 3'd3, 32'h003412E7, 3'd7, 1'b1, 1'b1, 1'b0},
        '{1'b0, 1'b0, 4'd0, 3'd2, 32'h0000C35A, 3'd1, 1'b0, 1'b1, 1'b1},
        '{1'b0, 1'b0, 4'd0, 3'd1, 32'h00000011, 3'd0, 1'b0, 1'b1, 1'b1},
        '{1'b0, 1'b0, 4'd0, 3'd1, 32'h00000081, 3'd7, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b0, 4'd0, 3'd2, 32'h0000D24B, 3'd7, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b1, 4'd2, 3'd1, 32'h0000006E, 3'd7, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b1, 4'd0, 3'd2, 32'h00000F99, 3'd7, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b0, 4'd0, 3'd2, 32'h00007227, 3'd1, 1'b0, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       speed_10 = 1'b0;
    logic       carrier_in = 1'b0;
    logic       byte_valid = 1'b0;
    logic       byte_sop = 1'b0;
    logic       byte_eop = 1'b0;
    logic       byte_err = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       byte_pop;
    logic       crs_dv;
    logic [1:0] rxd;

    int n_chk = 0;
    int n_fail = 0;

    logic [1:0] rec  [0:2047];
    logic [1:0] expd [0:63];

    always #2 clk = ~clk;

    rmii_rx_serializer #(.DATA_W(8), .PRE_LEN(PRE_LEN), .STRETCH(STRETCH)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .speed_10   (speed_10),
        .carrier_in (carrier_in),
        .byte_valid (byte_valid),
        .byte_sop   (byte_sop),
        .byte_eop   (byte_eop),
        .byte_err   (byte_err),
        .byte_data  (byte_data),
        .byte_pop   (byte_pop),
        .crs_dv     (crs_dv),
        .rxd        (rxd)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp_v);
        end
    endtask

    task automatic quiet_inputs();
        carrier_in = 1'b0;
        byte_valid = 1'b0;
        byte_sop   = 1'b0;
        byte_eop   = 1'b0;
        byte_err   = 1'b0;
        byte_data  = 8'h00;
    endtask

    // Drive one frame from the table and compare the recorded lanes
    task automatic run_vec(input vec_t v, input int num);
        int nb, first, idx, tens, n, ne, lead, exp_lead, d, pos, tail;
        bit seen, done, ok_pre, ok_dat, ok_tail, popped;
        int bad_act, bad_exp;
        string rq;
        nb = int'(v.nbytes);
        first = v.nosop ? 1 : 0;
        idx = 0; tens = 0; n = 0; seen = 0; done = 0;
        @(negedge clk);
        quiet_inputs();
        speed_10 = v.slow;
        @(negedge clk);
        for (int c = 0; c < 3000; c++) begin
            if (c != 0) @(negedge clk);
            carrier_in = (idx < nb) && (tens < 3);
            if (v.flip && c == 3) speed_10 = !v.slow;
            byte_valid = (idx < nb) && (c >= int'(v.gap));
            byte_data  = 8'(v.bytes >> (8 * idx));
            byte_sop   = (idx == first);
            byte_eop   = v.eop && (idx == nb - 1);
            byte_err   = (idx == int'(v.err_idx));
            #1;
            popped = byte_pop;
            if (crs_dv) begin
                rec[n] = rxd;
                n++;
                seen = 1;
                if (rxd == 2'b10) tens++;
            end else if (seen) begin
                done = 1;
                break;
            end
            if (popped) idx++;
        end
        chk(done, "R6", $sformatf("vec %0d activity ended", num), int'(done), 1);
        chk(rxd == 2'b00 && !crs_dv, "R6", $sformatf("vec %0d lanes after end", num),
            int'({crs_dv, rxd}), 0);
        // expected dibit list from the requirements
        ne = 0;
        if (int'(v.err_idx) != first) begin
            for (int k = 0; k < PRE_LEN; k++) begin expd[ne] = 2'b01; ne++; end
            expd[ne] = 2'b11; ne++;
            for (int i = first; i < nb; i++) begin
                if (i == int'(v.err_idx)) break;
                for (int j = 0; j < 4; j++) begin
                    expd[ne] = 2'(v.bytes >> (8 * i + 2 * j));
                    ne++;
                end
            end
        end
        d = v.slow ? STRETCH : 1;
        lead = 0;
        while (lead < n && rec[lead] == 2'b00) lead++;
        if (v.slow) begin
            chk(lead >= d && (lead % d) == 0, "R3/R9",
                $sformatf("vec %0d leading 00 run", num), lead, d);
        end else begin
            exp_lead = ((int'(v.gap) > 1) ? int'(v.gap) : 1) + (v.nosop ? 1 : 0);
            chk(lead == exp_lead, "R3", $sformatf("vec %0d leading 00 run", num),
                lead, exp_lead);
        end
        pos = lead; ok_pre = 1; ok_dat = 1; bad_act = 0; bad_exp = 0;
        for (int k = 0; k < ne; k++) begin
            for (int j = 0; j < d; j++) begin
                if (pos >= n || rec[pos] != expd[k]) begin
                    if (ok_pre && ok_dat) begin
                        bad_act = (pos < n) ? int'(rec[pos]) : -1;
                        bad_exp = int'(expd[k]);
                    end
                    if (k <= PRE_LEN) ok_pre = 0; else ok_dat = 0;
                end
                pos++;
            end
        end
        rq = v.flip ? "R10" : (v.slow ? "R9" : "R4");
        chk(ok_pre, rq, $sformatf("vec %0d preamble dibit", num), bad_act, bad_exp);
        rq = v.flip ? "R10" : (v.slow ? "R9" : "R5");
        chk(ok_dat, rq, $sformatf("vec %0d data dibit", num), bad_act, bad_exp);
        tail = n - pos;
        if (v.exp_err) begin
            ok_tail = (tail >= 1);
            for (int p = pos; p < n; p++) if (rec[p] != 2'b10) ok_tail = 0;
            rq = (!v.eop && v.err_idx == 3'd7) ? "R8" : "R7";
            chk(ok_tail, rq, $sformatf("vec %0d error tail length", num), tail, 1);
        end else begin
            chk(tail == 0, "R6", $sformatf("vec %0d extra dibits", num), tail, 0);
        end
        quiet_inputs();
        speed_10 = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check and still reports
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!crs_dv && rxd == 2'b00, "R1", "lanes during reset", int'({crs_dv, rxd}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: idle ignores offered bytes
        byte_valid = 1'b1; byte_sop = 1'b1; byte_data = 8'hC6;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk(!byte_pop && !crs_dv && rxd == 2'b00, "R2", "idle with byte offered",
                int'({byte_pop, crs_dv, rxd}), 0);
        end
        quiet_inputs();

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R3: carrier lost before any byte returns to idle
        @(negedge clk); carrier_in = 1'b1;
        @(negedge clk); #1;
        chk(crs_dv && rxd == 2'b00, "R3", "wait phase lanes", int'({crs_dv, rxd}), 4);
        @(negedge clk); carrier_in = 1'b0;
        @(negedge clk); #1;
        chk(!crs_dv, "R3", "carrier drop while waiting", int'(crs_dv), 0);

        // R1: reset in the middle of a frame
        @(negedge clk);
        carrier_in = 1'b1; byte_valid = 1'b1; byte_sop = 1'b1; byte_data = 8'hFF;
        repeat (12) @(negedge clk);
        #1;
        chk(crs_dv, "R1", "frame running before reset", int'(crs_dv), 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1;
        chk(!crs_dv && rxd == 2'b00, "R1", "lanes after mid-frame reset",
            int'({crs_dv, rxd}), 0);
        quiet_inputs();
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!crs_dv && rxd == 2'b00, "R2", "idle after reset release",
            int'({crs_dv, rxd}), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule